// File: doc/BRIEF.md
# Stereo Attenuation Mixer with Panning

This block takes the 1-bit square or noise outputs of four sound voices and turns them into a pair of signed 16-bit audio samples. Each voice has its own 4-bit attenuation code. A fixed logarithmic table maps that code to an amplitude, with 2 dB between steps. The loudest step is a quarter of the positive full scale, so the four voices can never clip when they are added together. An 8-bit panning register chooses whether each voice goes to the left output, to the right output, to both or to neither.

Samples are registered. They change only on a cycle in which the sample strobe is high, so downstream logic sees a steady value between strobes. One elaboration parameter selects mono operation: every active voice is added into the left output and the right output stays at zero. A second parameter negates both outputs arithmetically. Tone and noise generation happen upstream and are not part of this block.

Top module: `psg_pan_mixer`

## Requirements
- R1: The amplitude for attenuation code c (0..14) is the integer part of 8191 × 10^(−c/10): code 0 gives 8191, code 1 gives 6506 and code 14 gives 326. Code 15 gives 0.
- R2: A voice adds its amplitude to an output only while its voice bit is 1. The output is the sum of all such contributions.
- R3: Panning bit 4+i enables voice i (i = 0..3) on the left output, and panning bit i enables voice i on the right output.
- R4: After reset the panning register holds 0xFF, so every voice reaches both outputs.
- R5: On a clock edge where `pan_we` is 1, the panning register loads `pan_wdata`. While `pan_we` is 0, it keeps its value whatever `pan_wdata` does.
- R6: Both outputs are 0 after reset. They change only at a clock edge where `sample_stb` is 1, and they then show the voice bits, codes and panning present at that edge.
- R7: When NEGATE is 1, each output is the arithmetic negative of the sum it would otherwise carry.
- R8: When STEREO is 0, the left output carries the sum of all active voices regardless of panning, and the right output stays 0.
- R9: When every voice has code 15, both outputs become 0 at the next strobe, whatever the voice bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| voice_bits | input | 4 | Current output bit of voices 3..0 |
| att_codes | input | 16 | Attenuation code of voice i in bits [4i+3:4i] |
| pan_we | input | 1 | Panning register write enable |
| pan_wdata | input | 8 | Panning register write data |
| sample_stb | input | 1 | Capture a new output sample |
| left_out | output | 16 | Signed left sample |
| right_out | output | 16 | Signed right sample |

## Verification
The bench sweeps all 256 panning values against all 16 voice-bit patterns.
- A swapped left and right half would route each voice to the opposite side.
- An off-by-one in bit order would move a voice to its neighbour's enable.

Each voice is also swept through all sixteen codes with the others silenced. A mistyped table entry, or a code 15 that still makes sound, shows up there.

The bench also covers three timing cases:
- A register that follows its inputs without waiting for the strobe gives a new sample at the wrong time.
- A panning register that loads while the write enable is low takes the stray write data.
- A mono build that still obeys the panning register drops voices from the left output.

// File: rtl/psg_mix_pkg.sv
package psg_mix_pkg;
   localparam int unsigned ATT_BITS = 4;
   localparam int unsigned PEAK_AMP = 8191;   // 0x7FFF / 4, truncated
   localparam int unsigned AMP_BITS = 13;

   typedef logic [ATT_BITS-1:0] att_code_t;
   typedef logic [AMP_BITS-1:0] amp_t;
endpackage

// File: rtl/psg_att_rom.sv
module psg_att_rom
   import psg_mix_pkg::*;
#(
   parameter int AMP_W = AMP_BITS
) (
   input  att_code_t        code,
   output logic [AMP_W-1:0] amp
);
   generate
      if (AMP_W < int'(AMP_BITS)) begin : g_bad_width
         $error("psg_att_rom: AMP_W too narrow for the table");
      end
   endgenerate

   // 2 dB per step from one quarter of full scale, integer part kept
   always_comb begin
      case (code)
         4'd0:    amp = AMP_W'(8191);
         4'd1:    amp = AMP_W'(6506);
         4'd2:    amp = AMP_W'(5168);
         4'd3:    amp = AMP_W'(4105);
         4'd4:    amp = AMP_W'(3260);
         4'd5:    amp = AMP_W'(2590);
         4'd6:    amp = AMP_W'(2057);
         4'd7:    amp = AMP_W'(1634);
         4'd8:    amp = AMP_W'(1298);
         4'd9:    amp = AMP_W'(1031);
         4'd10:   amp = AMP_W'(819);
         4'd11:   amp = AMP_W'(650);
         4'd12:   amp = AMP_W'(516);
         4'd13:   amp = AMP_W'(410);
         4'd14:   amp = AMP_W'(326);
         default: amp = '0;
      endcase
   end
endmodule

// File: rtl/psg_pan_reg.sv
module psg_pan_reg #(
   parameter int NV = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [2*NV-1:0] wdata,
   output logic [NV-1:0]   left_en,
   output logic [NV-1:0]   right_en
);
   logic [2*NV-1:0] pan_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pan_q <= '1;
      else if (we) pan_q <= wdata;
   end

   assign left_en  = pan_q[2*NV-1:NV];
   assign right_en = pan_q[NV-1:0];

   assert_pan_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> pan_q == $past(wdata));
   assert_pan_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(pan_q));
   assert_pan_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> pan_q == '1);
endmodule

// File: rtl/psg_side_sum.sv
module psg_side_sum #(
   parameter int NV    = 4,
   parameter int AMP_W = 13,
   parameter int SUM_W = 16
) (
   input  logic [NV-1:0]       voice_on,
   input  logic [NV-1:0]       enable,
   input  logic [NV*AMP_W-1:0] amp_flat,
   output logic [SUM_W-1:0]    total
);
   generate
      if (SUM_W < AMP_W) begin : g_bad_sum
         $error("psg_side_sum: SUM_W narrower than AMP_W");
      end
   endgenerate

   always_comb begin
      total = '0;
      for (int i = 0; i < NV; i++) begin
         if (voice_on[i] && enable[i])
            total = total + SUM_W'(amp_flat[i*AMP_W +: AMP_W]);
      end
   end
endmodule

// File: rtl/psg_pan_mixer.sv
module psg_pan_mixer
   import psg_mix_pkg::*;
#(
   parameter int NUM_VOICES = 4,
   parameter int SAMPLE_W   = 16,
   parameter bit STEREO     = 1'b1,
   parameter bit NEGATE     = 1'b0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_VOICES-1:0]         voice_bits,
   input  logic [NUM_VOICES*ATT_BITS-1:0] att_codes,
   input  logic                          pan_we,
   input  logic [2*NUM_VOICES-1:0]       pan_wdata,
   input  logic                          sample_stb,
   output logic signed [SAMPLE_W-1:0]    left_out,
   output logic signed [SAMPLE_W-1:0]    right_out
);
   localparam int AMP_W = AMP_BITS;
   localparam int PEAK  = NUM_VOICES * int'(PEAK_AMP);

   generate
      if (NUM_VOICES < 1) begin : g_bad_nv
         $error("psg_pan_mixer: need at least one voice");
      end
      if (PEAK > (2 ** (SAMPLE_W - 1)) - 1) begin : g_bad_sw
         $error("psg_pan_mixer: SAMPLE_W cannot hold all voices at peak");
      end
   endgenerate

   logic [NUM_VOICES*AMP_W-1:0] amp_flat;
   logic [NUM_VOICES-1:0]       pan_left, pan_right;
   logic [NUM_VOICES-1:0]       en_left, en_right;
   logic [SAMPLE_W-1:0]         sum_left, sum_right;
   logic signed [SAMPLE_W-1:0]  smp_left, smp_right;

   genvar v;
   generate
      for (v = 0; v < NUM_VOICES; v++) begin : g_voice
         psg_att_rom #(.AMP_W(AMP_W)) u_rom (
            .code (att_codes[v*ATT_BITS +: ATT_BITS]),
            .amp  (amp_flat[v*AMP_W +: AMP_W])
         );
      end
   endgenerate

   psg_pan_reg #(.NV(NUM_VOICES)) u_pan (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (pan_we),
      .wdata    (pan_wdata),
      .left_en  (pan_left),
      .right_en (pan_right)
   );

   generate
      if (STEREO) begin : g_stereo
         assign en_left  = pan_left;
         assign en_right = pan_right;
      end else begin : g_mono
         logic unused_pan;
         assign unused_pan = ^{pan_left, pan_right};
         assign en_left    = '1;
         assign en_right   = '0;
      end
   endgenerate

   psg_side_sum #(.NV(NUM_VOICES), .AMP_W(AMP_W), .SUM_W(SAMPLE_W)) u_sum_l (
      .voice_on (voice_bits),
      .enable   (en_left),
      .amp_flat (amp_flat),
      .total    (sum_left)
   );

   psg_side_sum #(.NV(NUM_VOICES), .AMP_W(AMP_W), .SUM_W(SAMPLE_W)) u_sum_r (
      .voice_on (voice_bits),
      .enable   (en_right),
      .amp_flat (amp_flat),
      .total    (sum_right)
   );

   generate
      if (NEGATE) begin : g_neg
         assign smp_left  = -$signed(sum_left);
         assign smp_right = -$signed(sum_right);
      end else begin : g_pos
         assign smp_left  = $signed(sum_left);
         assign smp_right = $signed(sum_right);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_out  <= '0;
         right_out <= '0;
      end else if (sample_stb) begin
         left_out  <= smp_left;
         right_out <= smp_right;
      end
   end

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_stb |=> $stable(left_out) && $stable(right_out));
   assert_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb && (&att_codes) |=> left_out == 0 && right_out == 0);
   assert_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      left_out <= PEAK && left_out >= -PEAK && right_out <= PEAK && right_out >= -PEAK);

   generate
      if (STEREO) begin : g_chk_st
         assert_right_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
            sample_stb && pan_right == '0 |=> right_out == 0);
      end else begin : g_chk_mono
         assert_right_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
            right_out == 0);
      end
   endgenerate
endmodule

// File: tb/psg_pan_mixer_test.sv
`timescale 1ns/1ps
module psg_pan_mixer_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0]  vbits = '0;
   logic [15:0] atts = '0;
   logic        pan_we = 1'b0;
   logic [7:0]  pan_wd = '0;
   logic        stb = 1'b0;
   logic signed [15:0] l0, r0, l1, r1;
   int total = 0;
   int bad = 0;
   logic [7:0] cur_pan = 8'hFF;

   always #4 clk = ~clk;

   psg_pan_mixer #(.STEREO(1'b1), .NEGATE(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .voice_bits(vbits), .att_codes(atts),
      .pan_we(pan_we), .pan_wdata(pan_wd), .sample_stb(stb),
      .left_out(l0), .right_out(r0));

   psg_pan_mixer #(.STEREO(1'b0), .NEGATE(1'b1)) uut_mono (
      .clk(clk), .rst_n(rst_n), .voice_bits(vbits), .att_codes(atts),
      .pan_we(pan_we), .pan_wdata(pan_wd), .sample_stb(stb),
      .left_out(l1), .right_out(r1));

   function automatic int amp(input int code);
      if (code == 15) return 0;
      return $rtoi(8191.0 * (10.0 ** (-code / 10.0)));
   endfunction

   function automatic int side(input logic [3:0] b, input logic [15:0] a, input logic [3:0] en);
      int s = 0;
      for (int i = 0; i < 4; i++)
         if (b[i] && en[i]) s += amp(int'(a[i*4 +: 4]));
      return s;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic sample(input string req, input logic [3:0] b, input logic [15:0] a);
      @(negedge clk);
      vbits = b; atts = a; stb = 1'b1;
      @(negedge clk);
      stb = 1'b0;
      check(req, int'(l0), side(b, a, cur_pan[7:4]));
      check(req, int'(r0), side(b, a, cur_pan[3:0]));
      check("R7", int'(l1), -side(b, a, 4'hF));
      check("R8", int'(r1), 0);
   endtask

   task automatic write_pan(input logic [7:0] v);
      @(negedge clk);
      pan_we = 1'b1; pan_wd = v;
      @(negedge clk);
      pan_we = 1'b0;
      cur_pan = v;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic signed [15:0] hl, hr;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R6: reset state of outputs
      check("R6", int'(l0), 0);
      check("R6", int'(r0), 0);
      check("R6", int'(l1), 0);
      // R4: panning resets to all enabled
      sample("R4", 4'hF, 16'h0000);
      check("R1", int'(l0), 4 * 8191);

      // R1: every code on every voice, others silenced
      for (int v = 0; v < 4; v++)
         for (int c = 0; c < 16; c++) begin
            logic [15:0] a = 16'hFFFF;
            a[v*4 +: 4] = 4'(c);
            sample("R1", 4'hF, a);
         end
      check("R1", amp(0), 8191);
      check("R1", amp(1), 6506);
      check("R1", amp(14), 326);

      // R9: all silent with all bits on
      sample("R9", 4'hF, 16'hFFFF);

      // R2: bit patterns under several code sets
      for (int s = 0; s < 4; s++)
         for (int b = 0; b < 16; b++)
            sample("R2", 4'(b), 16'h3A70 + 16'(s * 16'h1111));

      // R3: every panning value against every bit pattern
      for (int p = 0; p < 256; p++) begin
         write_pan(8'(p));
         for (int b = 0; b < 16; b++)
            sample("R3", 4'(b), 16'hB603);
      end

      // R5: writes with enable low are ignored
      write_pan(8'h5A);
      @(negedge clk);
      pan_wd = 8'h0F;
      @(negedge clk);
      pan_wd = 8'hF0;
      sample("R5", 4'hF, 16'h0000);

      // R6: outputs hold without strobe while inputs move
      write_pan(8'hC3);
      sample("R6", 4'b1011, 16'h1234);
      hl = l0; hr = r0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         vbits = 4'(k); atts = 16'(k * 16'h0F0F);
         @(negedge clk);
         check("R6", int'(l0), int'(hl));
         check("R6", int'(r0), int'(hr));
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule